// File: doc/BRIEF.md
# GPIO Bank Controller with Interrupt Sensing

This block controls one bank of up to 32 general-purpose pins through a small register port with 32-bit data. Each pin works in one of two modes: general input/output, where a direction bit chooses whether the pad is driven from an output-data register, or interrupt input, where the pad is watched for a level or an edge and the result is latched in a per-pin status bit.

Pad inputs are brought into the clock domain by a two-flop synchroniser. An optional per-pin glitch filter then accepts a new value only after it has been seen unchanged for three synchronised samples. Sensing covers active-high or active-low levels, and rising, falling or both edges. Edge status is acknowledged by writing ones to a clear register. Per-pin enables are handled through a pair of registers: one write port clears enables where zeros are written, and the other sets enables where ones are written. A single interrupt line is high while any enabled pin has its status set.

Software reaches the block with single-cycle writes, strobed by `bus_en` and `bus_wr`. Reads are combinational from `bus_addr`. Byte offsets are fixed because driver software decodes them.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every register reads 0, `pad_oe` is 0 and `irq_out` is 0.
- R2: `pad_oe` bit i equals the direction bit (offset 0x04, 1 = output) while the mode bit (offset 0x00) is 0, and is 0 while the mode bit is 1. `pad_out` always equals the output-data register (offset 0x08).
- R3: Offset 0x0C reads the pad inputs after a two-flop synchroniser. A pad change is visible from the second rising clock edge after it.
- R4: A pin in level mode (mode bit 1, edge-select bit at offset 0x24 = 0) has its status bit (offset 0x10) follow the synchronised input XOR the polarity bit (offset 0x20, 1 = active low), one cycle later. Writing the clear register does not clear it.
- R5: A pin in edge mode (edge-select bit 1) sets its status on a rising edge when the polarity bit is 0, or on a falling edge when it is 1. The status holds until a 1 is written to that bit of the clear register (offset 0x14). Zero bits in a clear write leave status unchanged.
- R6: With its both-edge bit (offset 0x4C) set, an edge-mode pin sets its status on either edge, whatever its polarity bit says.
- R7: When a qualifying edge and a clear of the same pin fall in the same cycle, the status bit ends set.
- R8: Writing offset 0x1C sets the enable of every pin whose data bit is 1. Writing offset 0x18 clears the enable of every pin whose data bit is 0, and bits written as 1 have no effect. Reading offset 0x18 returns the enables.
- R9: `irq_out` is high exactly when some pin has both its status bit and its enable bit set.
- R10: When a pin's filter bit (offset 0x28) is set, a new input value is accepted only after three equal synchronised samples. A pulse lasting two clock cycles is rejected, and a step reaches the status register three cycles later than it does unfiltered.
- R11: A pin in general mode (mode bit 0) always has status 0, whatever its pad does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad output enables |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bound checker watches several properties on every cycle:
- Edge status cannot drop without a clear.
- An edge beats a simultaneous clear.
- Level status tracks the polarity-adjusted input.
- General-mode pins stay at zero status.
- Both mask writes take effect one cycle later.
- The interrupt line stays low while no enable is set.

Other behaviour needs the bench's scenarios:
- Exact latency through the synchroniser and the filter.
- Rejection of short pulses.
- The address decode of each register.
- A sweep of every pin through each of the five sensing kinds, checking status, acknowledge and interrupt values.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  // byte offsets decoded by driver software
  localparam logic [ADDR_W-1:0] A_MODE    = 8'h00;
  localparam logic [ADDR_W-1:0] A_DIR     = 8'h04;
  localparam logic [ADDR_W-1:0] A_ODATA   = 8'h08;
  localparam logic [ADDR_W-1:0] A_IDATA   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_STAT    = 8'h10;
  localparam logic [ADDR_W-1:0] A_ACK     = 8'h14;
  localparam logic [ADDR_W-1:0] A_MASKOFF = 8'h18;
  localparam logic [ADDR_W-1:0] A_MASKON  = 8'h1C;
  localparam logic [ADDR_W-1:0] A_POL     = 8'h20;
  localparam logic [ADDR_W-1:0] A_TRIG    = 8'h24;
  localparam logic [ADDR_W-1:0] A_FILT    = 8'h28;
  localparam logic [ADDR_W-1:0] A_DUAL    = 8'h4C;
endpackage

// File: rtl/gpb_sync_filter.sv
module gpb_sync_filter #(
  parameter int NPINS  = 32,
  parameter int STABLE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] filt,
  output logic [NPINS-1:0] sync_in,
  output logic [NPINS-1:0] sense
);
  localparam int DLY = STABLE - 1;

  logic [NPINS-1:0] meta_q, sync_q, clean_q, clean_d;
  logic [DLY-1:0][NPINS-1:0] dly_q, dly_d;
  logic [NPINS-1:0] agree_hi, agree_lo;

  // history window: current synchronised sample plus DLY older ones
  always_comb begin
    dly_d[0] = sync_q;
    for (int k = 1; k < DLY; k++) dly_d[k] = dly_q[k-1];
    agree_hi = sync_q;
    agree_lo = ~sync_q;
    for (int k = 0; k < DLY; k++) begin
      agree_hi = agree_hi & dly_q[k];
      agree_lo = agree_lo & ~dly_q[k];
    end
    clean_d = (clean_q | agree_hi) & ~agree_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= '0;
      sync_q  <= '0;
      dly_q   <= '0;
      clean_q <= '0;
    end else begin
      meta_q  <= pad_in;
      sync_q  <= meta_q;
      dly_q   <= dly_d;
      clean_q <= clean_d;
    end
  end

  assign sync_in = sync_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_sel
    assign sense[i] = filt[i] ? clean_q[i] : sync_q[i];
  end
endmodule

// File: rtl/gpb_detect.sv
module gpb_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] sense,
  input  logic [NPINS-1:0] mode,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] trig,
  input  logic [NPINS-1:0] dual,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] edge_hit,
  output logic [NPINS-1:0] stat
);
  logic [NPINS-1:0] prev_q, stat_q, stat_d;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, qual;
    assign rise = sense[i] & ~prev_q[i];
    assign fall = ~sense[i] & prev_q[i];
    assign qual = dual[i] ? (rise | fall) : (pol[i] ? fall : rise);
    assign edge_hit[i] = mode[i] & trig[i] & qual;

    always_comb begin
      if (!mode[i])      stat_d[i] = 1'b0;
      else if (!trig[i]) stat_d[i] = sense[i] ^ pol[i];
      else               stat_d[i] = edge_hit[i] | (stat_q[i] & ~clr[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= sense;
      stat_q <= stat_d;
    end
  end

  assign stat = stat_q;
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
  import gpb_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  sync_in,
  input  logic [NPINS-1:0]  stat,
  output logic [NPINS-1:0]  mode,
  output logic [NPINS-1:0]  dir,
  output logic [NPINS-1:0]  odata,
  output logic [NPINS-1:0]  pol,
  output logic [NPINS-1:0]  trig,
  output logic [NPINS-1:0]  filt,
  output logic [NPINS-1:0]  dual,
  output logic [NPINS-1:0]  en,
  output logic [NPINS-1:0]  clr
);
  logic [NPINS-1:0] wd;
  logic             wr_go;
  logic [NPINS-1:0] mode_q, dir_q, odata_q, pol_q, trig_q, filt_q, dual_q, en_q;
  logic [NPINS-1:0] mode_d, dir_d, odata_d, pol_d, trig_d, filt_d, dual_d, en_d;
  logic [NPINS-1:0] rd_bits;

  assign wd    = bus_wdata[NPINS-1:0];
  assign wr_go = bus_en & bus_wr;

  always_comb begin
    mode_d  = mode_q;
    dir_d   = dir_q;
    odata_d = odata_q;
    pol_d   = pol_q;
    trig_d  = trig_q;
    filt_d  = filt_q;
    dual_d  = dual_q;
    en_d    = en_q;
    clr     = '0;
    if (wr_go) begin
      case (bus_addr)
        A_MODE:    mode_d  = wd;
        A_DIR:     dir_d   = wd;
        A_ODATA:   odata_d = wd;
        A_POL:     pol_d   = wd;
        A_TRIG:    trig_d  = wd;
        A_FILT:    filt_d  = wd;
        A_DUAL:    dual_d  = wd;
        A_ACK:     clr     = wd;
        A_MASKOFF: en_d    = en_q & wd;
        A_MASKON:  en_d    = en_q | wd;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      dir_q   <= '0;
      odata_q <= '0;
      pol_q   <= '0;
      trig_q  <= '0;
      filt_q  <= '0;
      dual_q  <= '0;
      en_q    <= '0;
    end else if (wr_go) begin
      mode_q  <= mode_d;
      dir_q   <= dir_d;
      odata_q <= odata_d;
      pol_q   <= pol_d;
      trig_q  <= trig_d;
      filt_q  <= filt_d;
      dual_q  <= dual_d;
      en_q    <= en_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:    rd_bits = mode_q;
      A_DIR:     rd_bits = dir_q;
      A_ODATA:   rd_bits = odata_q;
      A_IDATA:   rd_bits = sync_in;
      A_STAT:    rd_bits = stat;
      A_MASKOFF: rd_bits = en_q;
      A_POL:     rd_bits = pol_q;
      A_TRIG:    rd_bits = trig_q;
      A_FILT:    rd_bits = filt_q;
      A_DUAL:    rd_bits = dual_q;
      default:   rd_bits = '0;
    endcase
    bus_rdata = '0;
    bus_rdata[NPINS-1:0] = rd_bits;
  end

  assign mode  = mode_q;
  assign dir   = dir_q;
  assign odata = odata_q;
  assign pol   = pol_q;
  assign trig  = trig_q;
  assign filt  = filt_q;
  assign dual  = dual_q;
  assign en    = en_q;
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpb_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int STABLE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_out
);
  logic [NPINS-1:0] sync_in, sense, stat, edge_hit, clr;
  logic [NPINS-1:0] mode, dir, odata, pol, trig, filt, dual, en;

  gpb_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sync_in(sync_in), .stat(stat), .mode(mode), .dir(dir), .odata(odata),
    .pol(pol), .trig(trig), .filt(filt), .dual(dual), .en(en), .clr(clr)
  );

  gpb_sync_filter #(.NPINS(NPINS), .STABLE(STABLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .filt(filt),
    .sync_in(sync_in), .sense(sense)
  );

  gpb_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .sense(sense), .mode(mode), .pol(pol),
    .trig(trig), .dual(dual), .clr(clr), .edge_hit(edge_hit), .stat(stat)
  );

  assign pad_oe  = dir & ~mode;
  assign pad_out = odata;
  assign irq_out = |(stat & en);
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [NPINS-1:0] mode,
  input logic [NPINS-1:0] pol,
  input logic [NPINS-1:0] trig,
  input logic [NPINS-1:0] sense,
  input logic [NPINS-1:0] en,
  input logic [NPINS-1:0] clr,
  input logic [NPINS-1:0] edge_hit,
  input logic [NPINS-1:0] stat,
  input logic [NPINS-1:0] pad_oe,
  input logic             irq_out
);
  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (pad_oe == '0 && irq_out == 1'b0);
  end

  assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat ^ $past(sense ^ pol)) & $past(mode & ~trig)) == '0);

  assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat & ~clr & mode & trig) & mode & trig & ~stat) == '0));

  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_hit & clr)) |=> ((stat & $past(edge_hit & clr)) == $past(edge_hit & clr)));

  assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && bus_addr == 8'h1C) |=>
      ((en & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

  assert_mask_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && bus_addr == 8'h18) |=>
      ((en & ~$past(bus_wdata[NPINS-1:0])) == '0));

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq_out);

  assert_general_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~$past(mode)) == '0);
endmodule

bind gpio_bank_ctrl gpb_checker #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mode(mode), .pol(pol),
  .trig(trig), .sense(sense), .en(en), .clr(clr), .edge_hit(edge_hit),
  .stat(stat), .pad_oe(pad_oe), .irq_out(irq_out)
);

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_en, bus_wr;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [N-1:0]  pad_in, pad_out, pad_oe;
  logic          irq_out;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_bank_ctrl #(.NPINS(N)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0] regs [12] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                              8'h18, 8'h1C, 8'h20, 8'h24, 8'h28, 8'h4C};
    rst_n = 1'b1; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0;
    #2 rst_n = 1'b0;
    waitc(3);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 12; i++) begin
      rd(regs[i], v);
      check("R1 register", v, 0);
    end
    check("R1 pad_oe", 32'(pad_oe), 0);
    check("R1 irq_out", 32'(irq_out), 0);

    // R2 direction / output data / mode forcing
    wr(8'h04, 32'hA5);
    wr(8'h08, 32'h3C);
    check("R2 pad_oe", 32'(pad_oe), 32'hA5);
    check("R2 pad_out", 32'(pad_out), 32'h3C);
    wr(8'h00, 32'h81);
    check("R2 pad_oe in irq mode", 32'(pad_oe), 32'h24);
    wr(8'h00, 0); wr(8'h04, 0);

    // R3 synchronised input data: visible after the second rising edge
    pad_in = 8'h96;
    waitc(1);
    check("R3 idata after one edge", bus_rdata & 0, 0);
    rd(8'h0C, v);
    check("R3 idata", v, 32'h96);
    pad_in = 8'h5A;
    @(negedge clk); bus_addr = 8'h0C; #1 check("R3 idata one edge", v & 32'hFF, 32'h96);
    check("R3 idata not yet", bus_rdata, 32'h96);
    @(negedge clk); #1 check("R3 idata two edges", bus_rdata, 32'h5A);

    // R11 general-mode pins never flag
    wr(8'h1C, 32'hFF); wr(8'h24, 32'hFF);
    pad_in = 8'h00; waitc(4); pad_in = 8'hFF; waitc(4);
    rd(8'h10, v);
    check("R11 status general", v, 0);
    check("R11 irq general", 32'(irq_out), 0);
    wr(8'h24, 0); wr(8'h18, 0); pad_in = '0; waitc(4);

    // R8 mask pair
    wr(8'h1C, 32'h0F); rd(8'h18, v); check("R8 mask set", v, 32'h0F);
    wr(8'h1C, 32'hF0); rd(8'h18, v); check("R8 mask set accumulates", v, 32'hFF);
    wr(8'h18, 32'hF5); rd(8'h18, v); check("R8 mask clear zeros", v, 32'hF5);
    wr(8'h18, 32'hFF); rd(8'h18, v); check("R8 ones no effect", v, 32'hF5);
    rd(8'h1C, v); check("R8 set port reads 0", v, 0);
    wr(8'h18, 0);

    // R9 masked pending
    wr(8'h00, 32'h04); pad_in = 8'h04; waitc(3);
    rd(8'h10, v);
    check("R9 status while masked", v, 32'h04);
    check("R9 irq masked", 32'(irq_out), 0);
    wr(8'h1C, 32'h04);
    check("R9 irq enabled", 32'(irq_out), 1);
    wr(8'h18, 0); wr(8'h00, 0); pad_in = '0; waitc(4);

    // R4 R5 R6 sweep: every pin, five sensing kinds
    for (int p = 0; p < N; p++) begin
      for (int k = 0; k < 5; k++) begin
        logic pl, edg, dl;
        logic [31:0] b;
        string tg;
        pl  = (k == 1) || (k == 3);
        edg = (k >= 2);
        dl  = (k == 4);
        b   = 32'd1 << p;
        tg  = dl ? "R6" : (edg ? "R5" : "R4");
        pad_in = pl ? b[N-1:0] : '0;
        wr(8'h18, 0); wr(8'h00, 0); waitc(4);
        wr(8'h20, pl ? b : 0); wr(8'h24, edg ? b : 0); wr(8'h4C, dl ? b : 0);
        wr(8'h00, b); wr(8'h1C, b); wr(8'h14, 32'hFFFF_FFFF); waitc(3);
        rd(8'h10, v);  check({tg, " idle status"}, v, 0);
        check("R9 idle irq", 32'(irq_out), 0);
        pad_in = pl ? '0 : b[N-1:0]; waitc(3);
        rd(8'h10, v);  check({tg, " active status"}, v, b);
        check("R9 active irq", 32'(irq_out), 1);
        wr(8'h14, ~b); waitc(2);
        rd(8'h10, v);  check("R5 zero clear bits no effect", v, b);
        wr(8'h14, b); waitc(2);
        rd(8'h10, v);  check({tg, " after clear"}, v, edg ? 0 : b);
        pad_in = pl ? b[N-1:0] : '0; waitc(3);
        rd(8'h10, v);  check({tg, " back to idle"}, v, dl ? b : 0);
        check("R9 irq follows", 32'(irq_out), dl ? 1 : 0);
      end
    end
    wr(8'h00, 0); wr(8'h20, 0); wr(8'h24, 0); wr(8'h4C, 0); wr(8'h18, 0);
    pad_in = '0; waitc(4);

    // R7 edge and clear in the same cycle
    wr(8'h24, 32'h01); wr(8'h00, 32'h01); wr(8'h14, 32'hFF); waitc(2);
    pad_in = 8'h01;
    waitc(1);
    wr(8'h14, 32'h01);
    rd(8'h10, v);
    check("R7 edge wins over clear", v, 32'h01);
    wr(8'h14, 32'h01); rd(8'h10, v);
    check("R7 later clear works", v, 0);
    pad_in = '0; waitc(4); wr(8'h14, 32'hFF);

    // R10 filter: short pulse rejected, long pulse accepted with extra delay
    wr(8'h28, 32'h01); waitc(6); wr(8'h14, 32'hFF);
    pad_in = 8'h01; waitc(2); pad_in = '0; waitc(10);
    rd(8'h10, v); check("R10 two-cycle pulse rejected", v, 0);
    pad_in = 8'h01; waitc(3);
    rd(8'h10, v); check("R10 not yet accepted", v, 0);
    waitc(1);
    rd(8'h10, v); check("R10 accepted after window", v, 32'h01);
    pad_in = '0; waitc(8); wr(8'h14, 32'hFF);
    wr(8'h28, 0); waitc(4); wr(8'h14, 32'hFF);
    pad_in = 8'h01; waitc(2); pad_in = '0; waitc(6);
    rd(8'h10, v); check("R10 unfiltered pulse caught", v, 32'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule